// File: doc/BRIEF.md
# Protocol Discovery Walker and Table

This block builds, right after start-up, the list of data-object protocols that a mailbox supports. When started, it first asks a separate exchange engine to abort the mailbox and so bring it to a known state. After a clean abort it runs a chain of discovery exchanges through the same engine. Each discovery request carries the standards-body vendor ID and object type 0, and its payload is one dword that names the index to query. Each response is one dword that holds a vendor ID, a protocol type and the index to ask for next. The walk starts at index 0, follows the returned next index, and ends after the response whose next index is 0. That last entry is still recorded.

Every returned pair goes into the next free slot of a small table, as the vendor ID shifted left by eight bits with the protocol type in the low byte. A combinational lookup port says whether a given vendor/type pair is supported. The discovery protocol itself always reports supported, whatever the table holds. The walk stops with an error code when any of these happens: the abort fails, an exchange fails, a response byte count is other than 4, or the table fills while the chain still points onward.

Top module: `proto_disc_walker`

## Requirements
- R1: Out of reset `walk_done_o` and `walk_err_o` are 0, `walk_fault_o` is 0, `tbl_count_o` is 0, and a lookup of any pair other than the discovery pair misses.
- R2: A pulse on `start_i` (while not walking) raises `abort_req_o` first. No exchange request is raised until `abort_done_i` arrives with `abort_ok_i` high.
- R3: An abort that completes with `abort_ok_i` low ends the walk with `walk_err_o`=1 and fault code 1, and no exchange is ever requested.
- R4: Every exchange request carries vendor `STD_VID`, type `DISC_TYPE`, and a payload with the queried index in bits [7:0] and zeros in bits [31:8]. The first index queried is 0.
- R5: The next index is taken from response bits [31:24] and becomes the next query. A response with next index 0 is stored and then ends the walk with `walk_done_o`=1, `walk_err_o`=0 and fault code 0.
- R6: Each accepted response stores one entry: vendor ID from bits [15:0] and type from bits [23:16]. `tbl_count_o` counts the stored entries and never exceeds `SLOTS`.
- R7: After a walk, `lk_hit_o` is 1 for every stored vendor/type pair. It is 0 for a pair that was not returned, including a stored vendor ID paired with another type.
- R8: A lookup of (`STD_VID`, `DISC_TYPE`) gives `lk_hit_o`=1 even when the table is empty.
- R9: An exchange completing with `xchg_ok_i` low stores nothing, ends the walk with fault code 2, and no further exchange is requested.
- R10: A successful exchange whose `xchg_rbytes_i` is not 4 stores nothing and ends the walk with fault code 3.
- R11: If the entry written into the last free slot has a nonzero next index, the walk ends with fault code 4. A chain of exactly `SLOTS` entries ending in next index 0 completes without error.
- R12: A new `start_i` after a finished or failed walk empties the table before walking again, so entries from the earlier walk no longer hit.
- R13: `xchg_req_o` and its payload stay unchanged until `xchg_done_i`. In the cycle after `xchg_done_i`, `xchg_req_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Pulse to begin abort and discovery walk |
| abort_req_o | output | 1 | Mailbox abort request, held until done |
| abort_done_i | input | 1 | Abort completion pulse |
| abort_ok_i | input | 1 | Abort succeeded, valid with done |
| xchg_req_o | output | 1 | Exchange request, held until done |
| xchg_vid_o | output | 16 | Request vendor ID |
| xchg_type_o | output | 8 | Request object type |
| xchg_wdata_o | output | 32 | Request payload dword (index in [7:0]) |
| xchg_done_i | input | 1 | Exchange completion pulse |
| xchg_ok_i | input | 1 | Exchange succeeded, valid with done |
| xchg_rbytes_i | input | BYTES_W | Received response byte count |
| xchg_rdata_i | input | 32 | Response payload dword |
| walk_done_o | output | 1 | Walk finished cleanly |
| walk_err_o | output | 1 | Walk ended with an error |
| walk_fault_o | output | 3 | 0 none, 1 abort, 2 exchange, 3 length, 4 overflow |
| tbl_count_o | output | CNT_W | Number of stored entries |
| lk_vid_i | input | 16 | Lookup vendor ID |
| lk_type_i | input | 8 | Lookup protocol type |
| lk_hit_o | output | 1 | Lookup pair is supported |

## Verification
The bench builds the block with `SLOTS` = 4 and an 8-bit byte-count input. With four slots, a five-entry chain is enough to reach the overflow fault, and a four-entry chain tests the exact-fill boundary without long runs. The modelled device spaces its indices three apart, so following the returned next index is distinguishable from simple counting. Response latency is stretched on some exchanges to exercise the hold rule.

// File: rtl/pdw_pkg.sv
package pdw_pkg;

   localparam int VID_W  = 16;
   localparam int TYPE_W = 8;
   localparam int IDX_W  = 8;
   localparam int DW     = 32;
   localparam int KEY_W  = VID_W + TYPE_W;

   typedef enum logic [2:0] {
      ERR_NONE  = 3'd0,
      ERR_ABORT = 3'd1,
      ERR_XCHG  = 3'd2,
      ERR_LEN   = 3'd3,
      ERR_OVFL  = 3'd4
   } fault_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ABORT,
      ST_ISSUE,
      ST_GAP,
      ST_DONE,
      ST_FAIL
   } walk_st_e;

   // response dword: next index on top, type in the middle, vendor low
   typedef struct packed {
      logic [IDX_W-1:0]  nxt;
      logic [TYPE_W-1:0] ptype;
      logic [VID_W-1:0]  vid;
   } disc_rsp_t;

   function automatic logic [DW-1:0] pack_query(input logic [IDX_W-1:0] idx);
      return {{(DW-IDX_W){1'b0}}, idx};
   endfunction

endpackage

// File: rtl/pdw_rsp_decode.sv
module pdw_rsp_decode
   import pdw_pkg::*;
#(
   parameter int BYTES_W   = 8,
   parameter int EXP_BYTES = 4
) (
   input  logic [DW-1:0]      rdata_i,
   input  logic [BYTES_W-1:0] rbytes_i,
   output disc_rsp_t          rsp_o,
   output logic               len_ok_o
);

   initial begin
      assert (BYTES_W >= 3) else $error("pdw_rsp_decode: BYTES_W too narrow for byte count");
      assert (EXP_BYTES == DW / 8) else $error("pdw_rsp_decode: EXP_BYTES must be one dword");
   end

   assign rsp_o    = disc_rsp_t'(rdata_i);
   assign len_ok_o = (rbytes_i == BYTES_W'(EXP_BYTES));

endmodule

// File: rtl/pdw_table.sv
module pdw_table
   import pdw_pkg::*;
#(
   parameter int              SLOTS     = 8,
   parameter logic [VID_W-1:0]  STD_VID   = 16'h0001,
   parameter logic [TYPE_W-1:0] DISC_TYPE = 8'h00,
   localparam int             CNT_W     = $clog2(SLOTS + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr_i,
   input  logic              wr_i,
   input  logic [VID_W-1:0]  wr_vid_i,
   input  logic [TYPE_W-1:0] wr_type_i,
   input  logic [VID_W-1:0]  lk_vid_i,
   input  logic [TYPE_W-1:0] lk_type_i,
   output logic              lk_hit_o,
   output logic [CNT_W-1:0]  count_o,
   output logic              last_free_o
);

   initial begin
      assert (SLOTS >= 1 && SLOTS <= 256) else $error("pdw_table: SLOTS out of range");
   end

   logic [KEY_W-1:0] key_q [SLOTS];
   logic [SLOTS-1:0] vld_q;
   logic [SLOTS-1:0] match;
   logic [CNT_W-1:0] cnt_q;
   logic [KEY_W-1:0] wr_key;
   logic [KEY_W-1:0] lk_key;
   logic             room;
   logic             disc_pair;

   // vendor shifted up by the type width, type in the low byte
   assign wr_key = {wr_vid_i, wr_type_i};
   assign lk_key = {lk_vid_i, lk_type_i};
   assign room   = (cnt_q < CNT_W'(SLOTS));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < SLOTS; s++) key_q[s] <= '0;
         vld_q <= '0;
      end else if (clr_i) begin
         vld_q <= '0;
      end else if (wr_i && room) begin
         for (int s = 0; s < SLOTS; s++) begin
            if (cnt_q == CNT_W'(s)) begin
               key_q[s] <= wr_key;
               vld_q[s] <= 1'b1;
            end
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             cnt_q <= '0;
      else if (clr_i)         cnt_q <= '0;
      else if (wr_i && room)  cnt_q <= cnt_q + 1'b1;
   end

   generate
      for (genvar s = 0; s < SLOTS; s++) begin : g_match
         assign match[s] = vld_q[s] && (key_q[s] == lk_key);
      end
   endgenerate

   assign disc_pair   = (lk_vid_i == STD_VID) && (lk_type_i == DISC_TYPE);
   assign lk_hit_o    = disc_pair || (|match);
   assign count_o     = cnt_q;
   assign last_free_o = (cnt_q == CNT_W'(SLOTS - 1));

   // R6: the count moves by one step at a time, or drops to empty
   a_r6_count_step: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q != $past(cnt_q)) |-> (cnt_q == $past(cnt_q) + 1'b1 || cnt_q == '0));

   // R6: never more entries than slots
   a_r6_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CNT_W'(SLOTS));

   // R12: a clear leaves the table empty
   a_r12_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
      clr_i |=> (cnt_q == '0 && vld_q == '0));

endmodule

// File: rtl/pdw_seq.sv
module pdw_seq
   import pdw_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic             abt_done_i,
   input  logic             abt_ok_i,
   input  logic             xchg_done_i,
   input  logic             xchg_ok_i,
   input  logic             len_ok_i,
   input  logic [IDX_W-1:0] rsp_nxt_i,
   input  logic             last_free_i,
   output logic             abt_req_o,
   output logic             xchg_req_o,
   output logic [IDX_W-1:0] qidx_o,
   output logic             tbl_clr_o,
   output logic             tbl_wr_o,
   output logic             walk_done_o,
   output logic             walk_err_o,
   output fault_e           fault_o
);

   walk_st_e         state_q, state_d;
   fault_e           fault_q, fault_d;
   logic [IDX_W-1:0] idx_q, idx_d;
   logic             can_start;
   logic             rsp_good;

   assign can_start = (state_q == ST_IDLE) || (state_q == ST_DONE) || (state_q == ST_FAIL);
   assign rsp_good  = (state_q == ST_ISSUE) && xchg_done_i && xchg_ok_i && len_ok_i;

   always_comb begin
      state_d = state_q;
      fault_d = fault_q;
      idx_d   = idx_q;
      unique case (state_q)
         ST_IDLE, ST_DONE, ST_FAIL: begin
            if (start_i) begin
               state_d = ST_ABORT;
               fault_d = ERR_NONE;
               idx_d   = '0;
            end
         end
         ST_ABORT: begin
            if (abt_done_i) begin
               if (abt_ok_i) begin
                  state_d = ST_ISSUE;
               end else begin
                  state_d = ST_FAIL;
                  fault_d = ERR_ABORT;
               end
            end
         end
         ST_ISSUE: begin
            if (xchg_done_i) begin
               if (!xchg_ok_i) begin
                  state_d = ST_FAIL;
                  fault_d = ERR_XCHG;
               end else if (!len_ok_i) begin
                  state_d = ST_FAIL;
                  fault_d = ERR_LEN;
               end else if (rsp_nxt_i == '0) begin
                  state_d = ST_DONE;
               end else if (last_free_i) begin
                  state_d = ST_FAIL;
                  fault_d = ERR_OVFL;
               end else begin
                  state_d = ST_GAP;
                  idx_d   = rsp_nxt_i;
               end
            end
         end
         ST_GAP:  state_d = ST_ISSUE;
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         fault_q <= ERR_NONE;
         idx_q   <= '0;
      end else begin
         state_q <= state_d;
         fault_q <= fault_d;
         idx_q   <= idx_d;
      end
   end

   assign abt_req_o   = (state_q == ST_ABORT);
   assign xchg_req_o  = (state_q == ST_ISSUE);
   assign qidx_o      = idx_q;
   assign tbl_clr_o   = can_start && start_i;
   assign tbl_wr_o    = rsp_good;
   assign walk_done_o = (state_q == ST_DONE);
   assign walk_err_o  = (state_q == ST_FAIL);
   assign fault_o     = fault_q;

   // R13: request and queried index held until the engine answers
   a_r13_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (xchg_req_o && !xchg_done_i) |=> (xchg_req_o && $stable(qidx_o)));

   // R13: one idle cycle follows every completion
   a_r13_req_gap: assert property (@(posedge clk) disable iff (!rst_n)
      (xchg_req_o && xchg_done_i) |=> !xchg_req_o);

   // R3: failed abort ends the walk without any exchange
   a_r3_abort_fail: assert property (@(posedge clk) disable iff (!rst_n)
      (abt_req_o && abt_done_i && !abt_ok_i) |=> (walk_err_o && fault_q == ERR_ABORT && !xchg_req_o));

   // R5: a good response pointing at index 0 completes the walk
   a_r5_zero_ends: assert property (@(posedge clk) disable iff (!rst_n)
      (xchg_req_o && xchg_done_i && xchg_ok_i && len_ok_i && rsp_nxt_i == '0) |=> (walk_done_o && !walk_err_o));

   // R9: a failed exchange stops the walk with its code
   a_r9_xchg_fail: assert property (@(posedge clk) disable iff (!rst_n)
      (xchg_req_o && xchg_done_i && !xchg_ok_i) |=> (walk_err_o && fault_q == ERR_XCHG));

   // R10: a wrong byte count stops the walk with its code
   a_r10_bad_len: assert property (@(posedge clk) disable iff (!rst_n)
      (xchg_req_o && xchg_done_i && xchg_ok_i && !len_ok_i) |=> (walk_err_o && fault_q == ERR_LEN));

endmodule

// File: rtl/proto_disc_walker.sv
module proto_disc_walker
   import pdw_pkg::*;
#(
   parameter int                SLOTS     = 8,
   parameter int                BYTES_W   = 8,
   parameter logic [VID_W-1:0]  STD_VID   = 16'h0001,
   parameter logic [TYPE_W-1:0] DISC_TYPE = 8'h00,
   localparam int               CNT_W     = $clog2(SLOTS + 1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start_i,
   output logic               abort_req_o,
   input  logic               abort_done_i,
   input  logic               abort_ok_i,
   output logic               xchg_req_o,
   output logic [VID_W-1:0]   xchg_vid_o,
   output logic [TYPE_W-1:0]  xchg_type_o,
   output logic [DW-1:0]      xchg_wdata_o,
   input  logic               xchg_done_i,
   input  logic               xchg_ok_i,
   input  logic [BYTES_W-1:0] xchg_rbytes_i,
   input  logic [DW-1:0]      xchg_rdata_i,
   output logic               walk_done_o,
   output logic               walk_err_o,
   output logic [2:0]         walk_fault_o,
   output logic [CNT_W-1:0]   tbl_count_o,
   input  logic [VID_W-1:0]   lk_vid_i,
   input  logic [TYPE_W-1:0]  lk_type_i,
   output logic               lk_hit_o
);

   initial begin
      assert (VID_W + TYPE_W + IDX_W == DW) else $error("proto_disc_walker: response fields must fill one dword");
   end

   disc_rsp_t        rsp;
   logic             len_ok;
   logic             last_free;
   logic             tbl_clr;
   logic             tbl_wr;
   logic [IDX_W-1:0] qidx;
   fault_e           fault;

   pdw_rsp_decode #(
      .BYTES_W   (BYTES_W),
      .EXP_BYTES (DW / 8)
   ) u_dec (
      .rdata_i  (xchg_rdata_i),
      .rbytes_i (xchg_rbytes_i),
      .rsp_o    (rsp),
      .len_ok_o (len_ok)
   );

   pdw_seq u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .start_i     (start_i),
      .abt_done_i  (abort_done_i),
      .abt_ok_i    (abort_ok_i),
      .xchg_done_i (xchg_done_i),
      .xchg_ok_i   (xchg_ok_i),
      .len_ok_i    (len_ok),
      .rsp_nxt_i   (rsp.nxt),
      .last_free_i (last_free),
      .abt_req_o   (abort_req_o),
      .xchg_req_o  (xchg_req_o),
      .qidx_o      (qidx),
      .tbl_clr_o   (tbl_clr),
      .tbl_wr_o    (tbl_wr),
      .walk_done_o (walk_done_o),
      .walk_err_o  (walk_err_o),
      .fault_o     (fault)
   );

   pdw_table #(
      .SLOTS     (SLOTS),
      .STD_VID   (STD_VID),
      .DISC_TYPE (DISC_TYPE)
   ) u_tbl (
      .clk         (clk),
      .rst_n       (rst_n),
      .clr_i       (tbl_clr),
      .wr_i        (tbl_wr),
      .wr_vid_i    (rsp.vid),
      .wr_type_i   (rsp.ptype),
      .lk_vid_i    (lk_vid_i),
      .lk_type_i   (lk_type_i),
      .lk_hit_o    (lk_hit_o),
      .count_o     (tbl_count_o),
      .last_free_o (last_free)
   );

   assign xchg_vid_o   = STD_VID;
   assign xchg_type_o  = DISC_TYPE;
   assign xchg_wdata_o = pack_query(qidx);
   assign walk_fault_o = fault;

   // R11: storing into the last slot with the chain still open is an overflow
   a_r11_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      (xchg_req_o && xchg_done_i && xchg_ok_i && len_ok && rsp.nxt != '0
       && tbl_count_o == CNT_W'(SLOTS - 1)) |=> (walk_err_o && walk_fault_o == 3'd4));

   // R5: done and error never together
   a_r5_done_err_excl: assert property (@(posedge clk) disable iff (!rst_n)
      !(walk_done_o && walk_err_o));

endmodule

// File: tb/proto_disc_walker_tb_top.sv
module proto_disc_walker_tb_top;

   localparam int SLOTS = 4;
   localparam int BW    = 8;
   localparam int CW    = $clog2(SLOTS + 1);
   localparam logic [15:0] SVID = 16'h0001;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          start;
   logic          abort_req, abort_done, abort_ok;
   logic          xchg_req;
   logic [15:0]   xchg_vid;
   logic [7:0]    xchg_type;
   logic [31:0]   xchg_wdata;
   logic          xchg_done, xchg_ok;
   logic [BW-1:0] xchg_rbytes;
   logic [31:0]   xchg_rdata;
   logic          walk_done, walk_err;
   logic [2:0]    walk_fault;
   logic [CW-1:0] tbl_count;
   logic [15:0]   lk_vid;
   logic [7:0]    lk_type;
   logic          lk_hit;

   int n_chk = 0;
   int n_bad = 0;
   logic [15:0] dv [16];
   logic [7:0]  dt [16];

   always #10 clk = ~clk;

   proto_disc_walker #(.SLOTS(SLOTS), .BYTES_W(BW)) dut_i (
      .clk(clk), .rst_n(rst_n), .start_i(start),
      .abort_req_o(abort_req), .abort_done_i(abort_done), .abort_ok_i(abort_ok),
      .xchg_req_o(xchg_req), .xchg_vid_o(xchg_vid), .xchg_type_o(xchg_type),
      .xchg_wdata_o(xchg_wdata), .xchg_done_i(xchg_done), .xchg_ok_i(xchg_ok),
      .xchg_rbytes_i(xchg_rbytes), .xchg_rdata_i(xchg_rdata),
      .walk_done_o(walk_done), .walk_err_o(walk_err), .walk_fault_o(walk_fault),
      .tbl_count_o(tbl_count), .lk_vid_i(lk_vid), .lk_type_i(lk_type), .lk_hit_o(lk_hit)
   );

   task automatic chk(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   task automatic look(input string tag, input logic [15:0] v, input logic [7:0] t, input logic exp);
      lk_vid  = v;
      lk_type = t;
      #1;
      chk(tag, $sformatf("lookup %h/%h", v, t), lk_hit, exp);
   endtask

   task automatic fill_dev(input int seed);
      for (int k = 0; k < 16; k++) begin
         dv[k] = 16'h1000 + 16'(seed * 16) + 16'(k);
         dt[k] = 8'h20 + 8'(seed) + 8'(k);
      end
   endtask

   // device model: entry k lives at index 3k; next is 3(k+1) or 0 at the end
   task automatic walk(input int n, input int fail_k, input int bad_k, input bit abt_good,
                       input int lat, output int reqs);
      int w;
      int exp_idx;
      int k;
      int nxt;
      logic [31:0] held;
      @(negedge clk) start = 1'b1;
      @(negedge clk) start = 1'b0;
      w = 0;
      while (!abort_req && w < 50) begin
         @(negedge clk);
         w++;
      end
      chk("R2", "abort requested after start", abort_req, 1);
      chk("R2", "no exchange before abort", xchg_req, 0);
      repeat (2) @(negedge clk);
      chk("R2", "abort still pending", abort_req, 1);
      chk("R2", "no exchange while abort pending", xchg_req, 0);
      abort_done = 1'b1;
      abort_ok   = abt_good;
      @(negedge clk);
      abort_done = 1'b0;
      abort_ok   = 1'b0;
      reqs    = 0;
      exp_idx = 0;
      w       = 0;
      while (!(walk_done || walk_err) && w < 500) begin
         if (xchg_req) begin
            chk("R4", "request vendor", xchg_vid, SVID);
            chk("R4", "request type", xchg_type, 0);
            chk("R4", "request payload index", xchg_wdata, {24'h0, 8'(exp_idx)});
            held = xchg_wdata;
            for (int c = 0; c < lat; c++) begin
               @(negedge clk);
               chk("R13", "request held", xchg_req, 1);
               chk("R13", "payload held", xchg_wdata, held);
            end
            k   = exp_idx / 3;
            nxt = (k + 1 < n) ? 3 * (k + 1) : 0;
            xchg_rdata  = {8'(nxt), dt[k], dv[k]};
            xchg_rbytes = (k == bad_k) ? BW'(8) : BW'(4);
            xchg_ok     = (k != fail_k);
            xchg_done   = 1'b1;
            reqs++;
            @(negedge clk);
            xchg_done = 1'b0;
            xchg_ok   = 1'b0;
            chk("R13", "request low after completion", xchg_req, 0);
            exp_idx = nxt;
         end else begin
            @(negedge clk);
         end
         w++;
      end
   endtask

   task automatic t_reset();
      chk("R1", "done after reset", walk_done, 0);
      chk("R1", "error after reset", walk_err, 0);
      chk("R1", "fault after reset", walk_fault, 0);
      chk("R1", "count after reset", tbl_count, 0);
      look("R1", 16'h1234, 8'h05, 1'b0);
      look("R8", SVID, 8'h00, 1'b1);
   endtask

   task automatic t_basic();
      int r;
      fill_dev(0);
      walk(3, -1, -1, 1'b1, 2, r);
      chk("R5", "exchanges in chain of 3", r, 3);
      chk("R5", "done", walk_done, 1);
      chk("R5", "no error", walk_err, 0);
      chk("R5", "fault none", walk_fault, 0);
      chk("R6", "count of 3", tbl_count, 3);
      for (int k = 0; k < 3; k++) look("R7", dv[k], dt[k], 1'b1);
      look("R7", dv[0], dt[1], 1'b0);
      look("R8", SVID, 8'h00, 1'b1);
   endtask

   task automatic t_single();
      int r;
      fill_dev(1);
      walk(1, -1, -1, 1'b1, 0, r);
      chk("R5", "single exchange", r, 1);
      chk("R5", "done single", walk_done, 1);
      chk("R6", "count of 1", tbl_count, 1);
      look("R5", dv[0], dt[0], 1'b1);
   endtask

   task automatic t_abort_fail();
      int r;
      walk(2, -1, -1, 1'b0, 0, r);
      chk("R3", "no exchange after failed abort", r, 0);
      chk("R3", "error flag", walk_err, 1);
      chk("R3", "fault code", walk_fault, 1);
      chk("R3", "done low", walk_done, 0);
      repeat (3) @(negedge clk);
      chk("R3", "still no exchange", xchg_req, 0);
      chk("R12", "table emptied by start", tbl_count, 0);
      look("R8", SVID, 8'h00, 1'b1);
   endtask

   task automatic t_xchg_fail();
      int r;
      fill_dev(2);
      walk(3, 1, -1, 1'b1, 1, r);
      chk("R9", "exchanges until failure", r, 2);
      chk("R9", "fault code", walk_fault, 2);
      chk("R9", "error flag", walk_err, 1);
      chk("R9", "failed entry not stored", tbl_count, 1);
      look("R9", dv[1], dt[1], 1'b0);
      repeat (3) @(negedge clk);
      chk("R9", "no further request", xchg_req, 0);
   endtask

   task automatic t_badlen();
      int r;
      fill_dev(3);
      walk(3, -1, 2, 1'b1, 0, r);
      chk("R10", "exchanges until bad length", r, 3);
      chk("R10", "fault code", walk_fault, 3);
      chk("R10", "bad entry not stored", tbl_count, 2);
      look("R10", dv[2], dt[2], 1'b0);
   endtask

   task automatic t_overflow();
      int r;
      fill_dev(4);
      walk(SLOTS + 1, -1, -1, 1'b1, 0, r);
      chk("R11", "exchanges before overflow", r, SLOTS);
      chk("R11", "fault code", walk_fault, 4);
      chk("R11", "error flag", walk_err, 1);
      chk("R6", "count at full", tbl_count, SLOTS);
   endtask

   task automatic t_exact();
      int r;
      fill_dev(0);
      walk(SLOTS, -1, -1, 1'b1, 0, r);
      chk("R11", "exact fill done", walk_done, 1);
      chk("R11", "exact fill fault none", walk_fault, 0);
      chk("R6", "count exact fill", tbl_count, SLOTS);
      look("R7", dv[SLOTS-1], dt[SLOTS-1], 1'b1);
   endtask

   task automatic t_restart();
      int r;
      logic [15:0] ov;
      logic [7:0]  ot;
      ov = dv[0];
      ot = dt[0];
      fill_dev(5);
      walk(2, -1, -1, 1'b1, 0, r);
      chk("R12", "second walk done", walk_done, 1);
      chk("R12", "second walk count", tbl_count, 2);
      look("R12", ov, ot, 1'b0);
      look("R12", dv[1], dt[1], 1'b1);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL R5 watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      rst_n = 1'b0;
      start = 1'b0;
      abort_done = 1'b0;
      abort_ok = 1'b0;
      xchg_done = 1'b0;
      xchg_ok = 1'b0;
      xchg_rbytes = '0;
      xchg_rdata = '0;
      lk_vid = '0;
      lk_type = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_basic();
      t_single();
      t_abort_fail();
      t_xchg_fail();
      t_badlen();
      t_overflow();
      t_exact();
      t_restart();
      repeat (2) @(negedge clk);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule